// File: doc/BRIEF.md
# Priority Region Memory Protection Checker

This block checks every memory access against a small table of programmable address regions. Each region has a base address, a size given as a power-of-two exponent, an enable bit and six permission bits. There are separate read, write and execute bits for privileged mode and for user mode. An access presents an address, an access kind and a privilege mode. Every enabled, well-formed region that covers the address is a candidate. The candidate with the highest index supplies the permissions, and the block either allows the access or reports a protection fault.

Regions may overlap, so a large low-numbered region can serve as a background. Region 0 is usually set to span the whole address space with privileged read/write and no user access. Smaller, higher-numbered regions then carve out windows with other rights. The table is loaded through a simple register-style write port. A base that is not aligned to its region size is stored, but that region is flagged and never matches.

The verdict is registered. It appears one cycle after the request, together with a copy of the address, kind and mode, and either the index of the deciding region or a no-match flag.

Top module: `prot_region_guard`

## Requirements
- R1: The block holds NREG regions (default 8), written by `cfg_we` with `cfg_idx` selecting the region. An access presented on the cycle after the write sees the new contents.
- R2: A region with exponent `e` covers the addresses whose bits at and above bit `e` equal those of its base. An exponent of AW or more covers the whole address space.
- R3: When several enabled regions cover an address, the one with the highest index decides, and its index is reported on `rsp_region`.
- R4: Permission bits are laid out as [0] privileged read, [1] privileged write, [2] privileged execute, [3] user read, [4] user write and [5] user execute. `acc_user`=1 selects the user bits. An access whose selected bit is 0 faults.
- R5: The access kind is encoded as 0 read, 1 write and 2 instruction fetch. Kind 3 is always denied, whatever the permissions.
- R6: An address covered by no usable region faults in both modes, sets `rsp_nomatch` and reports region 0.
- R7: Each request with `acc_valid`=1 yields exactly one `rsp_valid` pulse on the next cycle. That pulse carries the request's address, kind and mode. `rsp_fault` is 0 whenever `rsp_valid` is 0.
- R8: A write whose base has any bit set below the region's exponent sets the sticky `cfg_err`, which only reset clears. The region it wrote never matches until it is rewritten with an aligned base.
- R9: A region written with `cfg_en`=0 never matches, and lower regions decide for its addresses.
- R10: After reset all regions are disabled, `cfg_err` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_idx | input | IW | Region index to write |
| cfg_base | input | AW | Region base address |
| cfg_exp | input | EW | Region size exponent (size = 2^exp) |
| cfg_en | input | 1 | Region enable |
| cfg_perm | input | 6 | Permission bits, layout per R4 |
| cfg_err | output | 1 | Sticky misaligned-base flag |
| acc_valid | input | 1 | Access request |
| acc_addr | input | AW | Access address |
| acc_kind | input | 2 | Access kind, encoding per R5 |
| acc_user | input | 1 | 1 = user mode, 0 = privileged |
| rsp_valid | output | 1 | Verdict valid, one cycle after request |
| rsp_fault | output | 1 | Protection fault |
| rsp_nomatch | output | 1 | No usable region covered the address |
| rsp_region | output | IW | Index of the deciding region |
| rsp_addr | output | AW | Address of the judged access |
| rsp_kind | output | 2 | Kind of the judged access |
| rsp_user | output | 1 | Mode of the judged access |

## Verification
The hardest situation to reach is a three-deep overlap in which a small window sits inside a medium window inside the background region. Each level grants different rights, so only the priority order separates the outcomes. The bench builds such a nest, adds disabled and misaligned regions over the same addresses, and then sweeps every address of a 12-bit instance under every kind and both modes. A table model in the bench predicts each verdict. The table is later rewritten to drop the background region and to add a region whose exponent exceeds the address width, and the sweep is repeated.

// File: rtl/prot_region_guard.sv
module prot_region_guard #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int EW   = 6,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_base,
  input  logic [EW-1:0] cfg_exp,
  input  logic          cfg_en,
  input  logic [5:0]    cfg_perm,
  output logic          cfg_err,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic          acc_user,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic          rsp_nomatch,
  output logic [IW-1:0] rsp_region,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_kind,
  output logic          rsp_user
);

  function automatic logic [AW-1:0] low_mask(input logic [EW-1:0] e);
    logic [AW-1:0] m;
    for (int i = 0; i < AW; i++) m[i] = (i < int'(e));
    return m;
  endfunction

  logic [AW-1:0] base_q [NREG];
  logic [EW-1:0] exp_q  [NREG];
  logic [5:0]    perm_q [NREG];
  logic [NREG-1:0] en_q, bad_q, hit;

  logic          cfg_misaligned;
  assign cfg_misaligned = |(cfg_base & low_mask(cfg_exp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      bad_q   <= '0;
      cfg_err <= 1'b0;
      for (int r = 0; r < NREG; r++) begin
        base_q[r] <= '0;
        exp_q[r]  <= '0;
        perm_q[r] <= '0;
      end
    end else if (cfg_we && int'(cfg_idx) < NREG) begin
      base_q[cfg_idx] <= cfg_base;
      exp_q[cfg_idx]  <= cfg_exp;
      perm_q[cfg_idx] <= cfg_perm;
      en_q[cfg_idx]   <= cfg_en;
      bad_q[cfg_idx]  <= cfg_misaligned;
      if (cfg_misaligned) cfg_err <= 1'b1;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_hit
    assign hit[r] = en_q[r] && !bad_q[r] &&
                    (((acc_addr ^ base_q[r]) & ~low_mask(exp_q[r])) == '0);
  end

  logic [IW-1:0] sel;
  logic          any_hit;
  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int r = 0; r < NREG; r++)
      if (hit[r]) begin
        sel     = IW'(r);
        any_hit = 1'b1;
      end
  end

  logic [5:0] p;
  logic       allowed;
  assign p = perm_q[sel];
  always_comb begin
    case (acc_kind)
      2'd0:    allowed = acc_user ? p[3] : p[0];
      2'd1:    allowed = acc_user ? p[4] : p[1];
      2'd2:    allowed = acc_user ? p[5] : p[2];
      default: allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_nomatch <= 1'b0;
      rsp_region  <= '0;
      rsp_addr    <= '0;
      rsp_kind    <= '0;
      rsp_user    <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_fault <= acc_valid && (!any_hit || !allowed);
      if (acc_valid) begin
        rsp_nomatch <= !any_hit;
        rsp_region  <= sel;
        rsp_addr    <= acc_addr;
        rsp_kind    <= acc_kind;
        rsp_user    <= acc_user;
      end
    end
  end

endmodule

module prot_region_guard_chk #(
  parameter int AW = 32,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_err,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_kind,
  input logic          acc_user,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic          rsp_nomatch,
  input logic [IW-1:0] rsp_region,
  input logic [AW-1:0] rsp_addr,
  input logic [1:0]    rsp_kind,
  input logic          rsp_user
);

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  p_rsp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
  p_idle_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_fault);
  p_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (rsp_addr == $past(acc_addr) && rsp_kind == $past(acc_kind)
                   && rsp_user == $past(acc_user)));
  p_nomatch_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nomatch) |-> (rsp_fault && rsp_region == '0));
  p_kind3_denied_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd3) |=> rsp_fault);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_we));

endmodule

bind prot_region_guard prot_region_guard_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_err(cfg_err),
  .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
  .acc_user(acc_user), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_nomatch(rsp_nomatch), .rsp_region(rsp_region), .rsp_addr(rsp_addr),
  .rsp_kind(rsp_kind), .rsp_user(rsp_user)
);

// File: tb/test_prot_region_guard.sv
module test_prot_region_guard;
  localparam int NR = 8;
  localparam int AW = 12;
  localparam int EW = 4;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          cfg_we, cfg_en, acc_valid, acc_user;
  logic [2:0]    cfg_idx;
  logic [AW-1:0] cfg_base, acc_addr;
  logic [EW-1:0] cfg_exp;
  logic [5:0]    cfg_perm;
  logic [1:0]    acc_kind;
  logic          cfg_err, rsp_valid, rsp_fault, rsp_nomatch, rsp_user;
  logic [2:0]    rsp_region;
  logic [AW-1:0] rsp_addr;
  logic [1:0]    rsp_kind;

  prot_region_guard #(.NREG(NR), .AW(AW), .EW(EW)) i_prot_region_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_exp(cfg_exp), .cfg_en(cfg_en), .cfg_perm(cfg_perm),
    .cfg_err(cfg_err), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_user(acc_user), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_nomatch(rsp_nomatch), .rsp_region(rsp_region),
    .rsp_addr(rsp_addr), .rsp_kind(rsp_kind), .rsp_user(rsp_user));

  int total = 0, bad = 0;
  bit done = 0;

  logic [AW-1:0] m_base [NR];
  int            m_exp  [NR];
  logic          m_en   [NR];
  logic          m_bad  [NR];
  logic [5:0]    m_perm [NR];

  function automatic logic [AW-1:0] lmask(input int e);
    logic [AW-1:0] m;
    for (int i = 0; i < AW; i++) m[i] = (i < e);
    return m;
  endfunction

  task automatic predict(input logic [AW-1:0] a, input logic [1:0] k, input logic u,
                         output int reg_o, output logic nm, output logic flt);
    logic ok;
    reg_o = 0; nm = 1;
    for (int r = 0; r < NR; r++)
      if (m_en[r] && !m_bad[r] && ((a & ~lmask(m_exp[r])) == m_base[r])) begin
        reg_o = r; nm = 0;
      end
    if (k == 2'd3) ok = 0;
    else ok = m_perm[reg_o][int'(k) + (u ? 3 : 0)];
    flt = nm || !ok;
  endtask

  task automatic cfg_write(input int idx, input int base, input int e,
                           input logic en, input logic [5:0] perm);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = AW'(base); cfg_exp = EW'(e);
    cfg_en = en; cfg_perm = perm;
    @(negedge clk);
    cfg_we = 0;
    m_base[idx] = AW'(base); m_exp[idx] = e; m_en[idx] = en; m_perm[idx] = perm;
    m_bad[idx] = |(AW'(base) & lmask(e));
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [1:0] k, input logic u,
                        input string tag);
    int er; logic enm, ef;
    acc_valid = 1; acc_addr = a; acc_kind = k; acc_user = u;
    predict(a, k, u, er, enm, ef);
    @(negedge clk);
    acc_valid = 0;
    total++;
    if (!(rsp_valid && rsp_fault == ef && rsp_nomatch == enm && int'(rsp_region) == er
          && rsp_addr == a && rsp_kind == k && rsp_user == u)) begin
      bad++;
      $display("FAIL %s a=%h k=%0d u=%0d got v=%0d f=%0d nm=%0d reg=%0d ad=%h kd=%0d us=%0d exp v=1 f=%0d nm=%0d reg=%0d",
               tag, a, k, u, rsp_valid, rsp_fault, rsp_nomatch, rsp_region,
               rsp_addr, rsp_kind, rsp_user, ef, enm, er);
    end
  endtask

  task automatic check_bit(input logic got, input logic want, input string tag);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, want);
    end
  endtask

  task automatic sweep(input int lo, input int hi, input int step, input string tag);
    for (int a = lo; a <= hi; a += step)
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++)
          access(AW'(a), 2'(k), u[0], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_exp = 0; cfg_en = 0;
    cfg_perm = 0; acc_valid = 0; acc_addr = 0; acc_kind = 0; acc_user = 0;
    for (int r = 0; r < NR; r++) begin
      m_base[r] = 0; m_exp[r] = 0; m_en[r] = 0; m_bad[r] = 0; m_perm[r] = 0;
    end
    repeat (3) @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R10 rsp_valid in reset");
    check_bit(cfg_err, 1'b0, "R10 cfg_err in reset");
    rst_n = 1;
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R7 no response without request");
    access(12'h123, 2'd0, 1'b0, "R10/R6 empty table");
    access(12'h123, 2'd2, 1'b1, "R10/R6 empty table");

    // nested layout: background, windows, overlap, disabled region
    cfg_write(0, 12'h000, 12, 1, 6'h03);
    access(12'h555, 2'd1, 1'b0, "R1 write visible next cycle");
    cfg_write(2, 12'h400, 10, 1, 6'h3F);
    cfg_write(5, 12'h600, 8, 1, 6'h08);
    cfg_write(6, 12'h640, 4, 1, 6'h12);
    cfg_write(3, 12'h800, 11, 1, 6'h24);
    cfg_write(7, 12'h000, 4, 0, 6'h3F);
    check_bit(cfg_err, 1'b0, "R8 aligned writes keep cfg_err clear");
    access(12'h64A, 2'd1, 1'b1, "R3 deepest overlap wins");
    access(12'h005, 2'd0, 1'b1, "R9 disabled region ignored");
    access(12'h700, 2'd3, 1'b0, "R5 kind 3 denied");
    sweep(0, (1 << AW) - 1, 1, "R2/R3/R4/R5/R7/R9 full sweep");

    // misaligned base
    cfg_write(4, 12'h0A0, 8, 1, 6'h3F);
    check_bit(cfg_err, 1'b1, "R8 misaligned base sets cfg_err");
    access(12'h0A0, 2'd0, 1'b1, "R8 misaligned region never matches");
    sweep(12'h000, 12'h1FF, 1, "R8 misaligned sweep");
    cfg_write(4, 12'h100, 8, 1, 6'h09);
    check_bit(cfg_err, 1'b1, "R8 cfg_err sticky after aligned rewrite");
    sweep(12'h000, 12'h1FF, 3, "R8 rewritten region");

    // drop background; whole-space region via oversized exponent
    cfg_write(0, 12'h000, 12, 0, 6'h03);
    access(12'h300, 2'd0, 1'b0, "R6 no match in privileged mode");
    sweep(0, (1 << AW) - 1, 7, "R6/R9 no background");
    cfg_write(1, 12'h000, 15, 1, 6'h07);
    access(12'h300, 2'd2, 1'b0, "R2 exponent above width covers all");
    sweep(0, (1 << AW) - 1, 5, "R2/R3 oversized exponent");
    cfg_write(1, 12'h010, 15, 1, 6'h07);
    check_bit(cfg_err, 1'b1, "R8 nonzero base with full-span exponent");
    sweep(0, (1 << AW) - 1, 11, "R8/R6 full-span misaligned");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule